// File: doc/BRIEF.md
# Aligned Mantissa Add and Normalize Stage

This stage sits inside a fused multiply-add datapath, between exponent alignment and final rounding. It receives two 128-bit magnitudes that already share one exponent: the product magnitude and the addend magnitude. Before alignment, each had its leading one at bit 126. The stage also receives the sign of each operand and a flag for the round-toward-negative mode.

When the signs agree, the stage adds the magnitudes. When they differ, it subtracts the smaller magnitude from the larger one. It then normalizes the result, adjusts the exponent and narrows the 128-bit value to a 56-bit mantissa. That mantissa holds 53 significant bits followed by guard, round and sticky bits, and goes to the rounder. An exact cancellation is reported as a zero. The sign of that zero depends on the rounding mode.

Operands enter on a valid/ready stream, and results leave on a second valid/ready stream. A result is registered one clock after its operands are accepted. While a result waits on an output that is not ready, the stage holds it unchanged and accepts nothing new. The stage accepts a new operand set when its output register is empty or is being drained in the same cycle, so full throughput is kept when the consumer is always ready. The rounding-mode flag is a plain control pin and is sampled together with the operands.

Top module: `mant_addnorm`

## Requirements
- R1: When the two signs are equal, the magnitudes are added (low 64-bit half carrying into the high half). If bit 127 of the sum is clear, the exponent passes through unchanged. The result sign is the common sign.
- R2: When an equal-sign sum sets bit 127, the sum is shifted right by one. The bit shifted out is ORed into bit 0, and the exponent increases by one.
- R3: When the signs differ, the larger magnitude minus the smaller is computed. The larger magnitude is decided by comparing the high halves first and then the low halves. The result sign is the product sign when the product magnitude is strictly larger, and the addend sign otherwise.
- R4: An exact-zero difference gives res_zero=1, res_mant=0 and res_exp=0. Its res_sign is 1 only when rnd_down was 1 with those operands.
- R5: A nonzero difference is shifted left until its leading one reaches bit 126, and the exponent drops by the shift amount. If the high half is zero, a jump of 63 bits (when bit 63 is set) or 64 bits is taken first, followed by a leading-zero shift.
- R6: The output mantissa res_mant[55:0] takes normalized bits 126..72 as its bits 55..1. Its bit 0 is the OR of normalized bits 71..0, which is a sticky right shift by 71. Every nonzero result therefore has res_mant[55]=1.
- R7: A transfer in is made when in_valid and in_ready are both high at a clock edge. Its result has out_valid high after that edge. in_ready is high whenever out_valid is low or out_ready is high.
- R8: While out_valid is high and out_ready is low, out_valid and every result field hold their values on the next cycle.
- R9: During and directly after reset, out_valid is low and in_ready is high.
- R10: res_exp and exp_in are two's-complement values EXP_W bits wide, so exponents below the normal range stay negative rather than wrapping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand set is valid |
| in_ready | output | 1 | Stage can accept an operand set |
| prod_mag | input | 128 | Aligned product magnitude |
| prod_sign | input | 1 | Product sign (1 = negative) |
| add_mag | input | 128 | Aligned addend magnitude |
| add_sign | input | 1 | Addend sign (1 = negative) |
| exp_in | input | EXP_W (13) | Common exponent, signed |
| rnd_down | input | 1 | Round-toward-negative mode; selects the sign of a cancelled zero |
| out_valid | output | 1 | Result is valid |
| out_ready | input | 1 | Consumer accepts the result |
| res_sign | output | 1 | Result sign |
| res_exp | output | EXP_W (13) | Adjusted exponent, signed |
| res_mant | output | 56 | Normalized mantissa with guard, round and sticky bits |
| res_zero | output | 1 | Result is an exact zero |

## Verification
Every result is due on the first rising edge after its operand set is accepted. The bench drives its inputs and samples its outputs one nanosecond after each falling edge. At that point it records acceptances into a queue of expected results. It compares the head of that queue whenever a transfer out is about to take place, so with a stalling consumer the comparison waits as many cycles as the stall lasts. Any cycle that ends with out_valid high and out_ready low is followed by a check that the next cycle shows identical outputs.

// File: rtl/mant_addnorm_pkg.sv
package mant_addnorm_pkg;

  // Which arithmetic path a result took.
  typedef enum logic [1:0] {
    PATH_SUM   = 2'd0,
    PATH_P_BIG = 2'd1,
    PATH_A_BIG = 2'd2
  } path_e;

endpackage

// File: rtl/mag_addsub.sv
module mag_addsub
  import mant_addnorm_pkg::*;
#(
  parameter int W = 128
) (
  input  logic [W-1:0] p_mag,
  input  logic         p_sign,
  input  logic [W-1:0] a_mag,
  input  logic         a_sign,
  output logic [W-1:0] raw,
  output logic         sign,
  output path_e        path
);
  localparam int H = W / 2;

  logic [H-1:0] p_hi, p_lo, a_hi, a_lo;
  assign p_hi = p_mag[W-1:H];
  assign p_lo = p_mag[H-1:0];
  assign a_hi = a_mag[W-1:H];
  assign a_lo = a_mag[H-1:0];

  // Sum with carry from the low half into the high half.
  logic         sum_c;
  logic [H-1:0] sum_lo, sum_hi;
  assign {sum_c, sum_lo} = {1'b0, p_lo} + {1'b0, a_lo};
  assign sum_hi = p_hi + a_hi + {{(H-1){1'b0}}, sum_c};

  // Magnitude compare: high halves decide unless equal.
  logic a_ge;
  assign a_ge = (a_hi > p_hi) || ((a_hi == p_hi) && (a_lo >= p_lo));

  logic [H-1:0] big_hi, big_lo, sml_hi, sml_lo;
  assign big_hi = a_ge ? a_hi : p_hi;
  assign big_lo = a_ge ? a_lo : p_lo;
  assign sml_hi = a_ge ? p_hi : a_hi;
  assign sml_lo = a_ge ? p_lo : a_lo;

  logic         dif_b;
  logic [H-1:0] dif_lo, dif_hi;
  assign {dif_b, dif_lo} = {1'b0, big_lo} - {1'b0, sml_lo};
  assign dif_hi = big_hi - sml_hi - {{(H-1){1'b0}}, dif_b};

  always_comb begin
    if (p_sign == a_sign) begin
      raw  = {sum_hi, sum_lo};
      sign = a_sign;
      path = PATH_SUM;
    end else if (a_ge) begin
      raw  = {dif_hi, dif_lo};
      sign = a_sign;
      path = PATH_A_BIG;
    end else begin
      raw  = {dif_hi, dif_lo};
      sign = p_sign;
      path = PATH_P_BIG;
    end
  end

endmodule

// File: rtl/mag_normalize.sv
module mag_normalize
  import mant_addnorm_pkg::*;
#(
  parameter int W     = 128,
  parameter int EXP_W = 13
) (
  input  logic [W-1:0]            raw,
  input  path_e                   path,
  input  logic signed [EXP_W-1:0] exp_in,
  output logic [W-2:0]            norm,
  output logic signed [EXP_W-1:0] exp_out
);
  localparam int H      = W / 2;
  localparam int LEAD   = W - 2;
  localparam int JUMP_S = LEAD - (H - 1);   // jump when bit H-1 is set
  localparam int JUMP_L = H;                // jump otherwise
  localparam int SPAN   = LEAD - H + 1;     // bits scanned by the fine count
  localparam int CW     = $clog2(W);

  // Coarse jump for a zero high half.
  logic [W-2:0]            coarse;
  logic signed [EXP_W-1:0] exp_c;
  always_comb begin
    if (raw[W-1:H] == '0) begin
      if (raw[H-1]) begin
        coarse = raw[LEAD:0] << JUMP_S;
        exp_c  = exp_in - EXP_W'(JUMP_S);
      end else begin
        coarse = raw[LEAD:0] << JUMP_L;
        exp_c  = exp_in - EXP_W'(JUMP_L);
      end
    end else begin
      coarse = raw[LEAD:0];
      exp_c  = exp_in;
    end
  end

  // Fine count of zeros from bit LEAD downward.
  logic [CW-1:0] lz;
  always_comb begin
    lz = CW'(SPAN - 1);
    for (int i = SPAN - 1; i >= 0; i--) begin
      if (coarse[LEAD-i]) lz = CW'(i);
    end
  end

  always_comb begin
    if (path == PATH_SUM) begin
      if (raw[W-1]) begin
        norm    = {raw[W-1:2], raw[1] | raw[0]};
        exp_out = exp_in + EXP_W'(1);
      end else begin
        norm    = raw[LEAD:0];
        exp_out = exp_in;
      end
    end else begin
      norm    = coarse << lz;
      exp_out = exp_c - EXP_W'(lz);
    end
  end

endmodule

// File: rtl/sticky_shr.sv
module sticky_shr #(
  parameter int IN_W  = 127,
  parameter int OUT_W = 56
) (
  input  logic [IN_W-1:0]  din,
  output logic [OUT_W-1:0] dout
);
  localparam int SH = IN_W - OUT_W;

  generate
    if (SH > 0) begin : g_shift
      assign dout = {din[IN_W-1:SH+1], din[SH] | (|din[SH-1:0])};
    end else begin : g_pass
      assign dout = din[OUT_W-1:0];
    end
  endgenerate

endmodule

// File: rtl/mant_addnorm.sv
module mant_addnorm
  import mant_addnorm_pkg::*;
#(
  parameter int MANT_W = 128,
  parameter int EXP_W  = 13,
  parameter int OUT_W  = 56
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [MANT_W-1:0]       prod_mag,
  input  logic                    prod_sign,
  input  logic [MANT_W-1:0]       add_mag,
  input  logic                    add_sign,
  input  logic signed [EXP_W-1:0] exp_in,
  input  logic                    rnd_down,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic                    res_sign,
  output logic signed [EXP_W-1:0] res_exp,
  output logic [OUT_W-1:0]        res_mant,
  output logic                    res_zero
);
  localparam int NORM_W = MANT_W - 1;

  logic [MANT_W-1:0]       raw;
  logic                    mag_sign;
  path_e                   path;
  logic [NORM_W-1:0]       norm;
  logic signed [EXP_W-1:0] norm_exp;
  logic [OUT_W-1:0]        narrow;
  logic                    is_zero;

  mag_addsub #(.W(MANT_W)) u_addsub (
    .p_mag  (prod_mag),
    .p_sign (prod_sign),
    .a_mag  (add_mag),
    .a_sign (add_sign),
    .raw    (raw),
    .sign   (mag_sign),
    .path   (path)
  );

  mag_normalize #(.W(MANT_W), .EXP_W(EXP_W)) u_norm (
    .raw     (raw),
    .path    (path),
    .exp_in  (exp_in),
    .norm    (norm),
    .exp_out (norm_exp)
  );

  sticky_shr #(.IN_W(NORM_W), .OUT_W(OUT_W)) u_shr (
    .din  (norm),
    .dout (narrow)
  );

  assign is_zero  = (path != PATH_SUM) && (raw == '0);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      res_sign  <= 1'b0;
      res_exp   <= '0;
      res_mant  <= '0;
      res_zero  <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        res_zero <= is_zero;
        res_sign <= is_zero ? rnd_down : mag_sign;
        res_exp  <= is_zero ? '0 : norm_exp;
        res_mant <= is_zero ? '0 : narrow;
      end
    end
  end

endmodule

// File: rtl/mant_addnorm_chk.sv
module mant_addnorm_chk #(
  parameter int EXP_W = 13,
  parameter int OUT_W = 56
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic                    res_sign,
  input logic signed [EXP_W-1:0] res_exp,
  input logic [OUT_W-1:0]        res_mant,
  input logic                    res_zero
);

  // R7
  accept_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R7
  idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(res_mant) && $stable(res_exp)
                                && $stable(res_sign) && $stable(res_zero));

  // R4
  zero_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && res_zero |-> (res_mant == '0) && (res_exp == '0));

  // R6
  leading_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !res_zero |-> res_mant[OUT_W-1]);

endmodule

bind mant_addnorm mant_addnorm_chk #(.EXP_W(EXP_W), .OUT_W(OUT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .res_sign  (res_sign),
  .res_exp   (res_exp),
  .res_mant  (res_mant),
  .res_zero  (res_zero)
);

// File: tb/sim_mant_addnorm.sv
module sim_mant_addnorm;
  localparam int CLK_PERIOD = 10;
  localparam int EW = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [127:0] prod_mag = '0;
  logic prod_sign = 1'b0;
  logic [127:0] add_mag = '0;
  logic add_sign = 1'b0;
  logic signed [EW-1:0] exp_in = '0;
  logic rnd_down = 1'b0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic res_sign;
  logic signed [EW-1:0] res_exp;
  logic [55:0] res_mant;
  logic res_zero;

  always #(CLK_PERIOD/2) clk = ~clk;

  mant_addnorm u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .prod_mag(prod_mag), .prod_sign(prod_sign), .add_mag(add_mag),
    .add_sign(add_sign), .exp_in(exp_in), .rnd_down(rnd_down),
    .out_valid(out_valid), .out_ready(out_ready), .res_sign(res_sign),
    .res_exp(res_exp), .res_mant(res_mant), .res_zero(res_zero)
  );

  typedef struct {
    logic [127:0] p;
    logic [127:0] a;
    logic ps;
    logic asg;
    int e;
    logic rd;
  } stim_t;

  typedef struct {
    logic [55:0] m;
    logic s;
    logic z;
    logic signed [EW-1:0] e;
    string tag;
  } res_t;

  stim_t sq[$];
  res_t  eq[$];
  int checks = 0;
  int fails = 0;
  bit done = 0;

  localparam logic [127:0] ONE126 = 128'h1 << 126;

  function automatic res_t model(stim_t s);
    res_t r;
    logic [128:0] v;
    int msb;
    int e;
    logic stk;
    e = s.e;
    if (s.ps == s.asg) begin
      v = {1'b0, s.p} + {1'b0, s.a}; r.s = s.asg;
    end else if (s.a >= s.p) begin
      v = {1'b0, s.a} - {1'b0, s.p}; r.s = s.asg;
    end else begin
      v = {1'b0, s.p} - {1'b0, s.a}; r.s = s.ps;
    end
    if (v == '0) begin
      r.z = 1'b1; r.s = s.rd; r.m = '0; r.e = '0; r.tag = "R4";
      return r;
    end
    msb = -1;
    for (int i = 128; i >= 0; i--) if (v[i] && msb < 0) msb = i;
    if (msb > 126) begin
      stk = v[0]; v = v >> 1; v[0] = v[0] | stk; e = e + 1; r.tag = "R2";
    end else begin
      v = v << (126 - msb); e = e - (126 - msb);
      r.tag = (s.ps == s.asg) ? "R1" : "R3/R5";
    end
    r.z = 1'b0;
    r.m = v[126:71];
    r.m[0] = v[71] | (|v[70:0]);
    r.e = EW'(e);
    return r;
  endfunction

  task automatic check(bit ok, string req, string what, string act, string exp_s);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %s expected %s", req, what, act, exp_s);
    end
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  function automatic stim_t mk(logic [127:0] p, logic [127:0] a, logic ps, logic asg,
                               int e, logic rd);
    stim_t s;
    s.p = p; s.a = a; s.ps = ps; s.asg = asg; s.e = e; s.rd = rd;
    return s;
  endfunction

  initial begin
    repeat (30000) @(posedge clk);
    if (!done) begin
      check(1'b0, "WDOG", "watchdog", "hung", "finish");
      finish_up();
    end
  end

  initial begin
    logic [127:0] p, a;
    bit took = 0;
    bit stall = 0;
    int cyc = 0;
    logic [55:0] sm; logic ss, sz; logic signed [EW-1:0] se;
    res_t r;

    // Directed cases
    sq.push_back(mk(ONE126, ONE126 >> 3, 0, 0, 10, 0));                        // R1
    sq.push_back(mk(ONE126 | 128'h1, ONE126 | (ONE126 >> 1), 1, 1, -20, 0));   // R2 sticky
    sq.push_back(mk(ONE126 | (128'h1 << 100), ONE126, 1, 0, 5, 0));            // R3 product larger
    sq.push_back(mk(ONE126 >> 1, ONE126, 0, 1, 7, 0));                         // R3 addend larger
    sq.push_back(mk(ONE126, ONE126, 0, 1, 3, 0));                              // R4 rd=0
    sq.push_back(mk(ONE126 | 128'h5, ONE126 | 128'h5, 1, 0, 3, 1));            // R4 rd=1
    sq.push_back(mk(ONE126, ONE126 - (128'h1 << 63), 1, 0, 100, 0));           // R5 jump 63
    sq.push_back(mk(ONE126 | (128'h1 << 10), ONE126, 0, 1, 100, 0));           // R5 jump 64 + fine
    sq.push_back(mk(ONE126, ONE126 | 128'h1, 0, 1, 200, 1));                   // R5 diff of one
    sq.push_back(mk(ONE126, 128'h1, 0, 0, 0, 0));                              // R6 sticky only
    sq.push_back(mk(ONE126, ONE126 >> 71, 0, 0, -4000, 0));                    // R10 negative exp
    for (int k = 0; k < 80; k++) begin
      p = rnd128(); p[127] = 1'b0; p[126] = 1'b1;
      a = rnd128(); a[127] = 1'b0; a[126] = 1'b1;
      if ($urandom % 2) a = a >> ($urandom % 130); else p = p >> ($urandom % 130);
      sq.push_back(mk(p, a, 1'($urandom), 1'($urandom), int'($urandom % 400) - 200, 1'($urandom)));
    end
    for (int k = 0; k < 60; k++) begin   // near cancellation
      p = rnd128(); p[127] = 1'b0; p[126] = 1'b1;
      a = p ^ (rnd128() >> ($urandom % 127));
      a[127] = 1'b0; a[126] = 1'b1;
      sq.push_back(mk(p, a, 1'($urandom), 1'($urandom), int'($urandom % 400) - 200, 1'($urandom)));
    end

    // Reset
    repeat (3) @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R9", "out_valid in reset", $sformatf("%b", out_valid), "0");
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(out_valid == 1'b0 && in_ready == 1'b1, "R9", "after reset",
          $sformatf("v%b r%b", out_valid, in_ready), "v0 r1");

    while ((sq.size() > 0 || eq.size() > 0 || in_valid) && cyc < 5000) begin
      @(negedge clk);
      cyc++;
      if (took || !in_valid) begin
        if (sq.size() > 0) begin
          stim_t s;
          s = sq.pop_front();
          prod_mag = s.p; add_mag = s.a; prod_sign = s.ps; add_sign = s.asg;
          exp_in = EW'(s.e); rnd_down = s.rd; in_valid = 1'b1;
          r = model(s);
        end else in_valid = 1'b0;
      end
      out_ready = (cyc < 15) ? 1'b1 : (($urandom % 4) != 0);
      #1;
      if (stall) begin
        // R8 outputs held across a stall
        check(out_valid && res_mant == sm && res_exp == se && res_sign == ss && res_zero == sz,
              "R8", "hold", $sformatf("v%b m%h", out_valid, res_mant), $sformatf("v1 m%h", sm));
      end
      stall = out_valid && !out_ready;
      sm = res_mant; se = res_exp; ss = res_sign; sz = res_zero;
      if (!out_valid)
        check(in_ready, "R7", "in_ready when empty", $sformatf("%b", in_ready), "1");
      if (out_valid && out_ready) begin
        if (eq.size() == 0) check(1'b0, "R7", "unexpected result", "valid", "none");
        else begin
          res_t x;
          x = eq.pop_front();
          check(res_mant == x.m && res_exp == x.e && res_sign == x.s && res_zero == x.z,
                (x.tag == "R3/R5") ? "R3 R5 R6" : {x.tag, " R6 R10"}, "result",
                $sformatf("s%b e%0d m%h z%b", res_sign, res_exp, res_mant, res_zero),
                $sformatf("s%b e%0d m%h z%b", x.s, x.e, x.m, x.z));
        end
      end
      took = in_valid && in_ready;
      if (took) eq.push_back(r);
    end
    check(eq.size() == 0 && sq.size() == 0, "R7", "all results drained",
          $sformatf("%0d", eq.size()), "0");
    done = 1;
    finish_up();
  end

endmodule